// File: doc/BRIEF.md
# Open-Drain Data Line Repeater

This block joins two open-drain data lines, one facing the host and one facing a card, so that either end can signal to the other without a direction control. Each line is read back through a synchronizer, and for each line the block drives two enables: a pull-down that forces the line low, and a short high pull-up pulse. Whichever line falls first becomes the master. After a programmable delay the block pulls the other line, the slave, low. When the master lets go, the block drops the pull-down and drives the slave high for a set number of cycles, which gives a fast rising edge.

The card line is only usable while the sequencer's enable is high. While that enable is low, the card line is held low, both lines are ignored and any transfer in progress is abandoned. Once a transfer finishes, a new master can only be chosen after the pull-up pulse has ended and both lines read high again. Line voltages and resistor values are outside this logic.

Top module: `od_io_repeater`

## Requirements
- R1: While reset is high and on the first cycles after it, `host_pd`, `host_pu` and `card_pu` are 0 and `card_pd` is 1. A line level of 1 means released or high, and every drive output is active high.
- R2: With `card_en` high and the block idle, suppose `host_line` goes low before clock edge 1. Then `card_pd` rises at edge EDGE_DLY+3: two synchronizer edges, one edge-detect edge, then EDGE_DLY counting edges.
- R3: Card-first transfers mirror R2. `host_pd` rises at edge EDGE_DLY+3 after `card_line` falls, and the host release pulse then appears on `host_pu`.
- R4: Suppose the master line returns high before edge 1 while the slave is held low. At edge 3 the slave's pull-down drops and its pull-up pulse rises. The pulse stays high for exactly PU_LEN cycles, and then all drives are 0.
- R5: The master side's own `_pd` and `_pu` stay 0 for the whole transfer.
- R6: If both lines are first seen low on the same cycle, the host side is master: `card_pd` is driven and `host_pd` stays 0.
- R7: If the master line returns high before the edge delay has run out, the slave is never pulled low and no pulse is sent.
- R8: A falling edge that arrives during the pull-up pulse, or before both lines read high afterwards, never starts a transfer. Nothing is driven until the block has gone idle and a fresh falling edge is seen.
- R9: If `card_en` is sampled low, then from the next edge `card_pd` is 1 and the other three drives are 0, whatever either line does. Re-enabling does not start a transfer.
- R10: At most one of the four drive outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| card_en | input | 1 | Card line enable from the sequencer (activated and selected) |
| host_line | input | 1 | Level read back from the host-side line |
| card_line | input | 1 | Level read back from the card-side line |
| host_pd | output | 1 | Pull the host line low |
| host_pu | output | 1 | Drive the host line high (release pulse) |
| card_pd | output | 1 | Pull the card line low |
| card_pu | output | 1 | Drive the card line high (release pulse) |

## Verification
The assertions assume that `card_en` comes from the block's own clock domain, and that EDGE_DLY and PU_LEN are both at least 1. They also assume the line levels read back agree with the block's own drives, the way wired open-drain lines do. The bench models each line as low whenever the block's pull-down or the far-end device pulls it low, and high otherwise. It changes the device drives only on falling clock edges, so line levels pass through the synchronizer exactly as a real asynchronous line would. The only simultaneous fall the bench produces is the deliberate tie case. Each low level is held much longer than the edge delay, except in the short-glitch case.

// File: rtl/rep_pkg.sv
package rep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELAY,
    ST_HOLD,
    ST_PULSE,
    ST_SETTLE
  } rep_state_e;

  typedef enum logic {
    M_HOST = 1'b0,
    M_CARD = 1'b1
  } rep_master_e;
endpackage

// File: rtl/rep_sync.sv
module rep_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= RST_VAL;
          else     stg[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= RST_VAL;
          else     stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rep_fall.sv
module rep_fall #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= lvl;
  end

  assign fall = prev & ~lvl;
endmodule

// File: rtl/rep_timer.sv
module rep_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (!done)     cnt <= cnt + 1'b1;
  end

  // R4: the shared counter never runs past the window it is timing
  a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt < limit);
endmodule

// File: rtl/od_io_repeater.sv
module od_io_repeater
  import rep_pkg::*;
#(
  parameter int EDGE_DLY    = 20,
  parameter int PU_LEN      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic card_en,
  input  logic host_line,
  input  logic card_line,
  output logic host_pd,
  output logic host_pu,
  output logic card_pd,
  output logic card_pu
);
  localparam int MAXC = (EDGE_DLY > PU_LEN) ? EDGE_DLY : PU_LEN;
  localparam int CW   = $clog2(MAXC + 1);

  logic h_s, c_s, h_fall, c_fall;
  logic t_done, t_restart;
  logic [CW-1:0] t_limit;
  rep_state_e  st, st_n;
  rep_master_e mst, mst_n;
  logic master_lvl;

  rep_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst(rst), .d({host_line, card_line}), .q({h_s, c_s})
  );

  rep_fall #(.W(2)) u_fall (
    .clk(clk), .rst(rst), .lvl({h_s, c_s}), .fall({h_fall, c_fall})
  );

  assign t_limit   = (st == ST_PULSE) ? CW'(PU_LEN) : CW'(EDGE_DLY);
  assign t_restart = (st_n != st);

  rep_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .restart(t_restart), .limit(t_limit), .done(t_done)
  );

  assign master_lvl = (mst == M_HOST) ? h_s : c_s;

  always_comb begin
    st_n  = st;
    mst_n = mst;
    case (st)
      ST_IDLE: begin
        if (h_fall) begin
          st_n  = ST_DELAY;
          mst_n = M_HOST;
        end else if (c_fall) begin
          st_n  = ST_DELAY;
          mst_n = M_CARD;
        end
      end
      ST_DELAY: begin
        if (master_lvl)  st_n = ST_SETTLE;
        else if (t_done) st_n = ST_HOLD;
      end
      ST_HOLD:   if (master_lvl) st_n = ST_PULSE;
      ST_PULSE:  if (t_done)     st_n = ST_SETTLE;
      ST_SETTLE: if (h_s && c_s) st_n = ST_IDLE;
      default:   st_n = ST_IDLE;
    endcase
    if (!card_en) st_n = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      mst     <= M_HOST;
      host_pd <= 1'b0;
      host_pu <= 1'b0;
      card_pd <= 1'b1;
      card_pu <= 1'b0;
    end else begin
      st      <= st_n;
      mst     <= mst_n;
      host_pd <= (st_n == ST_HOLD)  && (mst_n == M_CARD);
      host_pu <= (st_n == ST_PULSE) && (mst_n == M_CARD);
      card_pd <= !card_en || ((st_n == ST_HOLD) && (mst_n == M_HOST));
      card_pu <= (st_n == ST_PULSE) && (mst_n == M_HOST);
    end
  end

  // R10: never more than one drive enabled at a time
  a_r10_one_drive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({host_pd, host_pu, card_pd, card_pu}));

  // R9: a disabled card side holds its line low and drives nothing else
  a_r9_disabled_hold: assert property (@(posedge clk) disable iff (rst)
    !card_en |=> (card_pd && !card_pu && !host_pd && !host_pu));

  // R4: a release pulse on the card side only follows a held low
  a_r4_pu_after_pd: assert property (@(posedge clk) disable iff (rst)
    $rose(card_pu) |-> $past(card_pd));

  // R2: holding the slave low is only reached through the edge delay
  a_r2_hold_after_delay: assert property (@(posedge clk) disable iff (rst)
    $rose(st == ST_HOLD) |-> $past(st == ST_DELAY));

  // R8: after a transfer no new master is picked before idle
  a_r8_no_new_master: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SETTLE) |=> (st == ST_SETTLE || st == ST_IDLE));

  // R6: a simultaneous fall gives the host side mastership
  a_r6_host_wins: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && h_fall && c_fall && card_en) |=> (mst == M_HOST));
endmodule

// File: tb/tb_od_io_repeater.sv
module tb_od_io_repeater;
  localparam int CLK_P = 10;
  localparam int D = 6;
  localparam int P = 4;

  typedef struct {
    int        cyc;
    logic [3:0] exp;
    string     req;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic card_en = 1'b0;
  logic h_drv = 1'b0;
  logic c_drv = 1'b0;
  logic host_pd, host_pu, card_pd, card_pu;
  logic host_line, card_line;
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  item_t sb[$];

  assign host_line = !(host_pd || h_drv);
  assign card_line = !(card_pd || c_drv);

  od_io_repeater #(.EDGE_DLY(D), .PU_LEN(P)) dut (
    .clk(clk), .rst(rst), .card_en(card_en),
    .host_line(host_line), .card_line(card_line),
    .host_pd(host_pd), .host_pu(host_pu), .card_pd(card_pd), .card_pu(card_pu)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected items as their cycle comes up
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc == cyc) begin
        checks++;
        if ({host_pd, host_pu, card_pd, card_pu} !== sb[i].exp) begin
          errors++;
          $display("FAIL %s cycle %0d: drives {hpd,hpu,cpd,cpu} actual %b expected %b",
                   sb[i].req, cyc, {host_pd, host_pu, card_pd, card_pu}, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  task automatic span(input int a, input int b, input logic [3:0] v, input string r);
    for (int c = a; c <= b; c++) sb.push_back('{c, v, r});
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // host_first: 1 host master, 0 card master; both: both lines fall together
  task automatic xfer(input bit host_first, input bit both, input string r_del, input string r_pls);
    int k, m;
    logic [3:0] hold_v, pls_v;
    hold_v = host_first ? 4'b0010 : 4'b1000;
    pls_v  = host_first ? 4'b0001 : 4'b0100;
    k = cyc;
    m = k + D + 6;
    if (host_first || both) h_drv = 1'b1;
    if (!host_first || both) c_drv = 1'b1;
    span(k + 1, k + 2 + D, 4'b0000, "R5");
    span(k + 3 + D, k + 3 + D, hold_v, r_del);
    span(k + 4 + D, m + 2, hold_v, "R5");
    step(D + 6);
    h_drv = 1'b0;
    c_drv = 1'b0;
    span(m + 3, m + 2 + P, pls_v, r_pls);
    span(m + 3 + P, m + P + 6, 4'b0000, r_pls);
    step(P + 8);
  endtask

  initial begin
    int k, m;
    // R1 reset state
    step(4);
    k = cyc;
    span(k + 1, k + 2, 4'b0010, "R1");
    rst = 1'b0;
    step(3);
    k = cyc;
    card_en = 1'b1;
    span(k + 1, k + 3, 4'b0000, "R1");
    step(5);

    xfer(1'b1, 1'b0, "R2", "R4");   // host master
    xfer(1'b0, 1'b0, "R3", "R3");   // card master
    xfer(1'b1, 1'b1, "R6", "R6");   // tie goes to host

    // R7 short low on host is not repeated
    k = cyc;
    span(k + 1, k + D + 10, 4'b0000, "R7");
    h_drv = 1'b1;
    step(2);
    h_drv = 1'b0;
    step(D + 12);

    // R8 fall during the pulse never starts a transfer
    k = cyc;
    m = k + D + 6;
    h_drv = 1'b1;
    span(k + 3 + D, m + 2, 4'b0010, "R8");
    step(D + 6);
    h_drv = 1'b0;
    span(m + 3, m + 2 + P, 4'b0001, "R4");
    span(m + 3 + P, m + P + 14, 4'b0000, "R8");
    step(3);
    h_drv = 1'b1;
    step(P + 5);
    h_drv = 1'b0;
    step(10);

    // R9 disabled card side
    k = cyc;
    card_en = 1'b0;
    span(k + 1, k + 12, 4'b0010, "R9");
    step(1);
    h_drv = 1'b1;
    c_drv = 1'b1;
    step(11);
    h_drv = 1'b0;
    c_drv = 1'b0;
    card_en = 1'b1;
    span(k + 13, k + 18, 4'b0000, "R9");
    step(8);

    // R10 sanity after everything: one more host transfer
    xfer(1'b1, 1'b0, "R10", "R10");

    step(4);
    if (sb.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: actual %0d items left expected 0", sb.size());
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule